// File: doc/BRIEF.md
# Lane Code-Group Synchronizer with Link Combiner

This block decides, lane by lane, whether a multi-lane serial receiver is locked to the code-group stream. Each lane receives three flags per cycle from its code-group decoder: a comma was seen, the code-group was valid, and the code-group was invalid. A lane starts out searching for commas with the comma aligner enabled. It declares lock after an unbroken chain of commas. Once locked, it absorbs isolated invalid code-groups through three graded error levels. A run of valid code-groups climbs back out of these levels, and only a further invalid code-group at the deepest level throws the lane out of lock.

Each locked lane also runs a no-comma timer. When the timer sees no comma for a set number of cycles, the lane's status changes to a distinct "locked, commas missing" value. The combiner ANDs the lock state of every lane into one link lock flag, so losing lock on any single lane takes the whole link down.

Top module: `lsync_link`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every lane reports status FAIL (code 0), has its comma-detect enable at 1, and link_ok is 0.
- R2: From the search state, a lane reaches lock only after four commas, each seen in a cycle without an invalid flag. Cycles that carry neither flag hold the progress. Status becomes OK (code 1) in the cycle after the edge that samples the fourth comma.
- R3: An invalid code-group received while a lane is partway through acquisition returns it to the search state, so four fresh commas are needed again.
- R4: The comma-detect enable of a lane is 1 exactly while its status is FAIL. Commas received while locked do not restart acquisition.
- R5: An invalid code-group on a locked lane with no pending errors moves it to error level 1 and clears its valid-run counter. Status stays non-FAIL.
- R6: At error levels 1 to 3, each valid code-group increments the run counter. The fourth consecutive valid code-group (counter at 3) moves the lane up one level (level 1 returns to clean lock) and clears the counter. Cycles with no flag neither count nor reset the run.
- R7: An invalid code-group at level 1 or 2 moves the lane one level deeper and clears the counter. At level 3 it drops the lane to the search state with status FAIL.
- R8: After NOCOMMA_LIMIT consecutive locked cycles with no comma, status becomes OK_NOC (code 2). A comma resets the timer and returns status to OK on the next cycle.
- R9: An invalid code-group while in OK_NOC follows the same error-level path as in OK, and status stays OK_NOC until a comma arrives or lock is lost.
- R10: link_ok is 1 exactly when every lane is locked (status OK or OK_NOC).
- R11: Lane i's status occupies bits [2i+1:2i] of lane_status, encoded FAIL=0, OK=1, OK_NOC=2.
- R12: When a comma and an invalid flag arrive in the same cycle, the invalid flag wins: a searching lane does not advance, and a locked lane takes the error path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, one code-group per lane per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cg_comma | input | NUM_LANES | Per-lane comma seen this cycle |
| cg_good | input | NUM_LANES | Per-lane valid code-group this cycle |
| cg_bad | input | NUM_LANES | Per-lane invalid code-group this cycle |
| lane_status | output | 2*NUM_LANES | Per-lane sync status, FAIL=0, OK=1, OK_NOC=2 |
| lane_cdet_en | output | NUM_LANES | Per-lane comma-detect enable |
| link_ok | output | 1 | All lanes locked |

## Verification
The error level and the valid-run counter never appear at the ports. A wrong level or count therefore shows up only later, as status falling to FAIL one invalid code-group too early or too late. The bench compares every lane against a behavioural model on every cycle and drives exact runs of three and four valid code-groups between errors, so an off-by-one in the counter or a skipped level shows up within a few cycles of the deciding code-group. A timer fault shows up as OK_NOC appearing one cycle away from the NOCOMMA_LIMIT boundary. Since cdet_en and link_ok follow from status, any wrong lock state also shows on them in the same cycle.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

  typedef enum logic [2:0] {
    ST_SEARCH = 3'd0,
    ST_ACQ1   = 3'd1,
    ST_ACQ2   = 3'd2,
    ST_ACQ3   = 3'd3,
    ST_LOCK   = 3'd4,
    ST_ERR1   = 3'd5,
    ST_ERR2   = 3'd6,
    ST_ERR3   = 3'd7
  } lane_st_e;

  typedef enum logic [1:0] {
    SS_FAIL   = 2'd0,
    SS_OK     = 2'd1,
    SS_OK_NOC = 2'd2
  } sync_stat_e;

  function automatic logic is_locked(lane_st_e s);
    return (s == ST_LOCK) || (s == ST_ERR1) || (s == ST_ERR2) || (s == ST_ERR3);
  endfunction

  // one comma further along the acquisition chain
  function automatic lane_st_e acq_step(lane_st_e s);
    case (s)
      ST_SEARCH: return ST_ACQ1;
      ST_ACQ1:   return ST_ACQ2;
      ST_ACQ2:   return ST_ACQ3;
      default:   return ST_LOCK;
    endcase
  endfunction

  // one invalid code-group deeper into the hysteresis
  function automatic lane_st_e err_deeper(lane_st_e s);
    case (s)
      ST_LOCK: return ST_ERR1;
      ST_ERR1: return ST_ERR2;
      ST_ERR2: return ST_ERR3;
      default: return ST_SEARCH;
    endcase
  endfunction

  // one level back towards clean lock after a valid run
  function automatic lane_st_e err_shallower(lane_st_e s);
    case (s)
      ST_ERR3: return ST_ERR2;
      ST_ERR2: return ST_ERR1;
      default: return ST_LOCK;
    endcase
  endfunction

endpackage

// File: rtl/lsync_lane_fsm.sv
module lsync_lane_fsm
  import lsync_pkg::*;
#(
  parameter int GOOD_RUN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     comma,
  input  logic     good,
  input  logic     bad,
  output lane_st_e st_q,
  output logic     locked_q,
  output logic     locked_nxt
);
  localparam int CNT_W = (GOOD_RUN > 2) ? $clog2(GOOD_RUN) : 1;
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(GOOD_RUN - 1);

  lane_st_e         st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // named events for the assertions
  logic ev_acq_abort, ev_err_enter, ev_level_up, ev_drop;

  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    ev_acq_abort = 1'b0;
    ev_err_enter = 1'b0;
    ev_level_up  = 1'b0;
    ev_drop      = 1'b0;
    case (st_q)
      ST_SEARCH: begin
        if (!bad && comma) st_d = acq_step(st_q);
      end
      ST_ACQ1, ST_ACQ2, ST_ACQ3: begin
        if (bad) begin
          st_d         = ST_SEARCH;
          ev_acq_abort = 1'b1;
        end else if (comma) begin
          st_d = acq_step(st_q);
        end
      end
      ST_LOCK: begin
        if (bad) begin
          st_d         = err_deeper(st_q);
          cnt_d        = '0;
          ev_err_enter = 1'b1;
        end
      end
      default: begin
        if (bad) begin
          st_d    = err_deeper(st_q);
          cnt_d   = '0;
          ev_drop = (st_q == ST_ERR3);
        end else if (good) begin
          if (cnt_q == RUN_LAST) begin
            st_d        = err_shallower(st_q);
            cnt_d       = '0;
            ev_level_up = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_SEARCH;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign locked_q   = is_locked(st_q);
  assign locked_nxt = is_locked(st_d);

  assert_acq_only_by_comma_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> ($past(comma) && !$past(bad) && $past(st_q) == ST_ACQ3));

  assert_acq_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_acq_abort) |=> (st_q == ST_SEARCH));

  assert_err_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && bad) |=> (st_q == ST_ERR1));

  assert_level_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_level_up |=> (locked_q && st_q != $past(st_q)));

  assert_deep_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ERR3 && bad) |=> (st_q == ST_SEARCH));

  assert_bad_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEARCH && bad) |=> (st_q == ST_SEARCH));

endmodule

// File: rtl/lsync_nocomma_timer.sv
module lsync_nocomma_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic locked_nxt,
  input  logic comma,
  output logic noc
);
  localparam int TMR_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(LIMIT - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             ev_expire;

  assign ev_expire = locked_nxt && !comma && (tmr_q == TMR_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= '0;
      noc   <= 1'b0;
    end else if (!locked_nxt || comma) begin
      tmr_q <= '0;
      noc   <= 1'b0;
    end else if (ev_expire) begin
      noc <= 1'b1;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  assert_comma_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    comma |=> !noc);

  assert_expire_needs_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noc) |-> ($past(locked_nxt) && !$past(comma)));

endmodule

// File: rtl/lsync_link.sv
module lsync_link
  import lsync_pkg::*;
#(
  parameter int NUM_LANES     = 4,
  parameter int GOOD_RUN      = 4,
  parameter int NOCOMMA_LIMIT = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LANES-1:0]   cg_comma,
  input  logic [NUM_LANES-1:0]   cg_good,
  input  logic [NUM_LANES-1:0]   cg_bad,
  output logic [2*NUM_LANES-1:0] lane_status,
  output logic [NUM_LANES-1:0]   lane_cdet_en,
  output logic                   link_ok
);
  logic [NUM_LANES-1:0] locked;
  logic [NUM_LANES-1:0] noc;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    lane_st_e   st;
    logic       lk_nxt;
    sync_stat_e stat;

    lsync_lane_fsm #(.GOOD_RUN(GOOD_RUN)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .comma     (cg_comma[i]),
      .good      (cg_good[i]),
      .bad       (cg_bad[i]),
      .st_q      (st),
      .locked_q  (locked[i]),
      .locked_nxt(lk_nxt)
    );

    lsync_nocomma_timer #(.LIMIT(NOCOMMA_LIMIT)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .locked_nxt(lk_nxt),
      .comma     (cg_comma[i]),
      .noc       (noc[i])
    );

    always_comb begin
      if (!locked[i])  stat = SS_FAIL;
      else if (noc[i]) stat = SS_OK_NOC;
      else             stat = SS_OK;
    end

    assign lane_status[2*i +: 2] = stat;
    assign lane_cdet_en[i]       = !locked[i];

    assert_cdet_tracks_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_cdet_en[i] |-> (lane_status[2*i +: 2] == SS_FAIL));

    assert_lane_fail_drops_link_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_status[2*i +: 2] == SS_FAIL) |-> !link_ok);
  end

  assign link_ok = &locked;

endmodule

// File: tb/lsync_link_bench.sv
`timescale 1ns/1ps
module lsync_link_bench;
  localparam int N   = 4;
  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] comma = '0, good = '0, bad = '0;
  logic [2*N-1:0] lane_status;
  logic [N-1:0]   lane_cdet_en;
  logic           link_ok;

  always #2.5 clk = ~clk;

  lsync_link #(.NUM_LANES(N), .GOOD_RUN(4), .NOCOMMA_LIMIT(LIM)) u_lsync_link (
    .clk(clk), .rst_n(rst_n), .cg_comma(comma), .cg_good(good), .cg_bad(bad),
    .lane_status(lane_status), .lane_cdet_en(lane_cdet_en), .link_ok(link_ok));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model: phase 0 search, 1..3 acquiring, 4 clean lock, 5..7 error levels
  int m_ph[N], m_run[N], m_quiet[N], m_noc[N];

  function automatic int stat_of(int l);
    return int'(lane_status[2*l +: 2]);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < N; l++) begin
      m_ph[l] = 0; m_run[l] = 0; m_quiet[l] = 0; m_noc[l] = 0;
    end
  endtask

  task automatic model_step();
    for (int l = 0; l < N; l++) begin
      int p = m_ph[l];
      if (p == 0) begin
        if (!bad[l] && comma[l]) p = 1;
      end else if (p <= 3) begin
        if (bad[l]) p = 0;
        else if (comma[l]) p = p + 1;
      end else if (p == 4) begin
        if (bad[l]) begin p = 5; m_run[l] = 0; end
      end else begin
        if (bad[l]) begin p = (p == 7) ? 0 : p + 1; m_run[l] = 0; end
        else if (good[l]) begin
          if (m_run[l] == 3) begin p = p - 1; m_run[l] = 0; end
          else m_run[l]++;
        end
      end
      m_ph[l] = p;
      if (p < 4 || comma[l]) begin m_quiet[l] = 0; m_noc[l] = 0; end
      else if (m_quiet[l] == LIM - 1) m_noc[l] = 1;
      else m_quiet[l]++;
    end
  endtask

  task automatic compare(string req);
    int all = 1;
    for (int l = 0; l < N; l++) begin
      int e = (m_ph[l] < 4) ? 0 : (m_noc[l] ? 2 : 1);
      chk({req, " status"}, stat_of(l), e);
      chk({req, " cdet R4"}, int'(lane_cdet_en[l]), (m_ph[l] < 4) ? 1 : 0);
      if (m_ph[l] < 4) all = 0;
    end
    chk({req, " link R10"}, int'(link_ok), all);
  endtask

  // inputs are already set at a falling edge
  task automatic tick(string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic set_lane(int l, bit c, bit g, bit b);
    comma[l] = c; good[l] = g; bad[l] = b;
  endtask

  task automatic idle_all();
    comma = '0; good = '1; bad = '0;
  endtask

  task automatic rnd(int n, int pb, int pc, int pg, string req);
    for (int k = 0; k < n; k++) begin
      for (int l = 0; l < N; l++) begin
        int r = $urandom_range(99);
        bit b = (r < pb);
        bit c = !b && (r < pb + pc);
        bit g = !b && (r < pb + pc + pg);
        set_lane(l, c, g, b);
      end
      tick(req);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    model_reset();
    repeat (3) @(negedge clk);
    for (int l = 0; l < N; l++) begin
      chk("R1 reset status", stat_of(l), 0);
      chk("R1 reset cdet", int'(lane_cdet_en[l]), 1);
    end
    chk("R1 reset link", int'(link_ok), 0);
    rst_n = 1'b1;
    compare("R1");

    // R2: four commas to lock, check status after each
    comma = '1; good = '1;
    for (int k = 0; k < 3; k++) begin
      tick("R2");
      chk("R2 not yet locked", stat_of(0), 0);
    end
    tick("R2");
    chk("R2 locked after fourth comma R11", stat_of(0), 1);
    chk("R10 all lanes locked", int'(link_ok), 1);

    // R4: more commas while locked keep lock
    tick("R4");
    chk("R4 commas while locked", stat_of(1), 1);

    // R8: quiet run to expiry
    idle_all();
    for (int k = 0; k < LIM - 1; k++) tick("R8");
    chk("R8 one before limit", stat_of(0), 1);
    tick("R8");
    chk("R8 expiry gives OK_NOC", stat_of(0), 2);

    // R9: error in OK_NOC keeps OK_NOC; comma returns to OK
    set_lane(0, 0, 0, 1); tick("R9");
    chk("R9 bad in OK_NOC", stat_of(0), 2);
    set_lane(0, 1, 1, 0); tick("R8");
    chk("R8 comma returns OK", stat_of(0), 1);

    // R5/R6/R7 on lane 1: bad, 3 good, bad, bad -> level 3, bad -> FAIL
    idle_all();
    set_lane(1, 0, 0, 1); tick("R5");
    chk("R5 level1 still locked", stat_of(1), 2);
    set_lane(1, 0, 1, 0);
    for (int k = 0; k < 3; k++) tick("R6");
    set_lane(1, 0, 0, 1); tick("R7");
    tick("R7");
    chk("R7 level3 still locked", stat_of(1), 2);
    tick("R7");
    chk("R7 drop from level3", stat_of(1), 0);
    chk("R10 link drops", int'(link_ok), 0);

    // R6 on lane 2: bad, 4 good (back to lock), then 3 bad stays locked, 4th drops
    set_lane(1, 0, 1, 0);
    set_lane(2, 0, 0, 1); tick("R6");
    set_lane(2, 0, 0, 0); tick("R6");
    set_lane(2, 0, 1, 0);
    for (int k = 0; k < 4; k++) tick("R6");
    set_lane(2, 0, 0, 1);
    for (int k = 0; k < 3; k++) tick("R6");
    chk("R6 recovered lane survives three errors", stat_of(2) != 0, 1);
    tick("R7");
    chk("R7 fourth error drops", stat_of(2), 0);

    // R12 on lane 1 (searching): comma+bad does not advance
    set_lane(2, 0, 1, 0);
    set_lane(1, 1, 1, 1); tick("R12");
    set_lane(1, 1, 1, 0);
    for (int k = 0; k < 3; k++) tick("R12");
    chk("R12 comma with bad ignored", stat_of(1), 0);
    tick("R12");
    chk("R12 lock after four clean commas", stat_of(1), 1);

    // R3 on lane 2: two commas, bad, three commas -> still FAIL
    set_lane(2, 1, 1, 0); tick("R3"); tick("R3");
    set_lane(2, 0, 0, 1); tick("R3");
    set_lane(2, 1, 1, 0);
    for (int k = 0; k < 3; k++) tick("R3");
    chk("R3 abort restarts acquisition", stat_of(2), 0);
    tick("R3");
    chk("R3 lock after full chain", stat_of(2), 1);

    // random mixes
    rnd(1500, 3, 10, 80, "R2 R5 R6 R7 mix");
    rnd(1000, 20, 20, 50, "R3 R7 R12 heavy errors");
    rnd(1000, 2, 1, 90, "R8 R9 sparse commas");
    rnd(500, 0, 50, 30, "R2 R4 comma rich");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule